// File: doc/BRIEF.md
# Packet Buffer Allocation Unit

This block keeps track of a small pool of fixed-size packet buffers for a network controller. It does not hold packet data. It hands out buffer indices, records which indices are in use in a bitmap, and keeps three short queues of indices:

- the pending-transmit queue, for buffers waiting to be sent;
- the completed-transmit queue, for buffers that have been sent but not yet reclaimed;
- the receive queue, for buffers that hold received frames.

Software drives the block through a byte-wide register port with a 4-bit address and a bank-select register. Commands are written as opcodes. Software reads back allocation results, queue heads, free-buffer counts and interrupt status. A single level interrupt reflects the status bits that are enabled in the mask.

On the line side, the transmitter sees a request level and the list of pending buffers. A `tx_start` pulse drains every pending buffer at once. The transmitter then reports each finished buffer with a `tx_done` pulse and the buffer number. A finished buffer is freed at once when auto-release is enabled. Otherwise it goes into the completed-transmit queue, where software acknowledges it through the interrupt register. The receiver sees which buffer it would get next. It claims that buffer with a `rx_req` pulse, and the claimed buffer is appended to the receive queue.

Top module: `pba_unit`

## Requirements
- R1: After reset:
  - the bitmap is empty and the free count (bank 0, offset 1) reads 4;
  - the size register (bank 0, offset 0) reads 4;
  - the completed-transmit head (bank 2, offset 4) and the receive head (bank 2, offset 5) read 0x80;
  - status (bank 2, offset 12) reads 0x04;
  - the mask and `irq` are zero.
- R2: Commands are written to bank 2, offset 0, with the opcode in bits 7:5:
  - 1 allocate; 2 reset pool; 3 pop receive; 4 pop receive and free;
  - 5 free the buffer named by the packet-number register (bank 2, offset 2); 6 queue that buffer for transmit; 7 reset transmit queues.
  
  Allocate puts the lowest free index in the result register (bank 2, offset 3) and sets status bit 3. When all 4 buffers are in use, allocate puts 0x80 there and clears bit 3.
- R3: The free command clears the named buffer's bitmap bit, and the free count rises by one.
- R4: The queue command appends to the pending-transmit queue:
  - `tx_req` rises and status bit 2 (transmit-empty) drops;
  - a `tx_start` pulse empties the whole queue in one cycle, and bit 2 returns.
- R5: A `tx_done` pulse handles one finished buffer:
  - with auto-release off (bank 0, offset 2, bit 0 = 0), the buffer number is appended to the completed-transmit queue unless that queue already holds 4 entries, in which case the number is dropped;
  - with auto-release on, the buffer is freed and the queue is left unchanged.
- R6: Writing bank 2, offset 12 clears the stored status bits given by the value AND 0xD6. If bit 1 of the value is set, one entry is popped from the completed-transmit queue. Status bit 1 stays set while that queue is non-empty, and bit 3 cannot be acknowledged.
- R7: `irq` is high exactly when status AND mask (bank 2, offset 13) is non-zero.
- R8: An `rx_req` pulse takes the lowest free buffer (`rx_buf_num`), appends it to the receive queue and sets status bit 0. When the pool is full the pulse is ignored. Opcode 3 pops the head. Opcode 4 pops the head and frees that buffer.
- R9: The reset-pool command clears the bitmap, all three queues, the allocation result and status bit 3. The reset-transmit command clears only the pending and completed queues.
- R10: Offset 14 is the bank select (3 bits) in every bank. Unmapped locations read 0, and writes to them change nothing.
- R11: When `rx_req` and an allocate command arrive in the same cycle, the receiver gets the lowest free buffer and the allocate command gets the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 4 | Register offset within the window |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational from addr and bank) |
| irq | output | 1 | Level interrupt |
| tx_start | input | 1 | Transmitter takes all pending buffers |
| tx_done | input | 1 | One buffer finished transmitting |
| tx_done_num | input | 2 | Number of the finished buffer |
| tx_req | output | 1 | Pending-transmit queue non-empty |
| tx_pend_cnt | output | 3 | Pending-transmit queue length |
| tx_pend_list | output | 8 | Pending entries, head in bits 1:0 |
| rx_req | input | 1 | Receiver claims a buffer |
| rx_buf_num | output | 2 | Buffer a receive claim would get |
| rx_pool_full | output | 1 | All buffers in use |

## Verification
The hardest state to reach is a completed-transmit queue that is already full when a fifth completion arrives. Only transmit-done pulses with auto-release off fill that queue, and only acknowledge writes drain it. The bench sends five completions in a row and then pops with four acknowledge writes. It checks each head in order, and then checks that the queue reads empty instead of returning the fifth number. The same-cycle collision of a receive claim with a register allocate is reached by raising `rx_req` in the very cycle the allocate command is written.

// File: rtl/pba_pkg.sv
package pba_pkg;
    localparam int DW = 8;
    localparam int BANKW = 3;

    typedef enum logic [2:0] {
        OP_NOP        = 3'd0,
        OP_ALLOC      = 3'd1,
        OP_RST_POOL   = 3'd2,
        OP_POP_RX     = 3'd3,
        OP_POP_RX_REL = 3'd4,
        OP_RELEASE    = 3'd5,
        OP_QUEUE_TX   = 3'd6,
        OP_RST_TXQ    = 3'd7
    } pool_op_e;

    localparam logic [DW-1:0] FAIL_CODE = 8'h80;
    localparam logic [DW-1:0] ACK_MASK  = 8'hD6;

    localparam int ST_RCV   = 0;
    localparam int ST_TX    = 1;
    localparam int ST_TXE   = 2;
    localparam int ST_ALLOC = 3;

    localparam logic [3:0] OFF_BANK   = 4'd14;
    localparam logic [3:0] B0_SIZE    = 4'd0;
    localparam logic [3:0] B0_FREE    = 4'd1;
    localparam logic [3:0] B0_CTRL    = 4'd2;
    localparam logic [3:0] B2_CMD     = 4'd0;
    localparam logic [3:0] B2_PNUM    = 4'd2;
    localparam logic [3:0] B2_RESULT  = 4'd3;
    localparam logic [3:0] B2_TXDONE  = 4'd4;
    localparam logic [3:0] B2_RXHEAD  = 4'd5;
    localparam logic [3:0] B2_STATUS  = 4'd12;
    localparam logic [3:0] B2_MASK    = 4'd13;
endpackage

// File: rtl/pba_queue.sv
module pba_queue #(
    parameter int DEPTH = 4,
    parameter int IDXW  = 2,
    parameter int CW    = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  pop,
    input  logic                  push,
    input  logic [IDXW-1:0]       push_val,
    output logic [CW-1:0]         cnt,
    output logic [IDXW-1:0]       head,
    output logic [DEPTH*IDXW-1:0] entries
);
    typedef struct packed {
        logic [DEPTH-1:0][IDXW-1:0] ent;
        logic [CW-1:0]              cnt;
    } q_st_t;

    q_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.cnt = '0;
        end else if (pop && st_q.cnt != '0) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                st_d.ent[i] = st_q.ent[i+1];
            end
            st_d.cnt = st_q.cnt - 1'b1;
        end
        if (push && st_d.cnt < CW'(DEPTH)) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (CW'(i) == st_d.cnt) st_d.ent[i] = push_val;
            end
            st_d.cnt = st_d.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt     = st_q.cnt;
    assign head    = st_q.ent[0];
    assign entries = st_q.ent;

    // R5: a push into a full queue is dropped and leaves the contents alone
    p_full_push_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !clr && st_q.cnt == CW'(DEPTH))
        |=> (st_q.cnt == CW'(DEPTH) && $stable(st_q.ent)));

    // R6: a pop on a non-empty queue moves the second entry to the head
    p_pop_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !clr && !push && st_q.cnt > CW'(1))
        |=> (st_q.ent[0] == $past(st_q.ent[1]) && st_q.cnt == $past(st_q.cnt) - 1'b1));
endmodule

// File: rtl/pba_pool.sv
module pba_pool #(
    parameter int NBUF = 4,
    parameter int IDXW = 2,
    parameter int CW   = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_all,
    input  logic            rx_take,
    input  logic            reg_take,
    input  logic [NBUF-1:0] rel_mask,
    output logic [IDXW-1:0] rx_idx,
    output logic            rx_ok,
    output logic [IDXW-1:0] reg_idx,
    output logic            reg_ok,
    output logic [CW-1:0]   free_cnt,
    output logic            full
);
    typedef struct packed {
        logic [NBUF-1:0] used;
    } pool_st_t;

    pool_st_t st_d, st_q;
    logic [NBUF-1:0] rx_set, reg_set, reg_view;

    function automatic logic [IDXW-1:0] lowest_zero(input logic [NBUF-1:0] v);
        logic [IDXW-1:0] r;
        r = '0;
        for (int i = NBUF - 1; i >= 0; i--) begin
            if (!v[i]) r = IDXW'(i);
        end
        return r;
    endfunction

    always_comb begin
        full     = &st_q.used;
        rx_ok    = !full;
        rx_idx   = lowest_zero(st_q.used);
        rx_set   = (rx_take && rx_ok) ? (NBUF'(1) << rx_idx) : '0;
        reg_view = st_q.used | rx_set;
        reg_ok   = !(&reg_view);
        reg_idx  = lowest_zero(reg_view);
        reg_set  = (reg_take && reg_ok) ? (NBUF'(1) << reg_idx) : '0;
        free_cnt = '0;
        for (int i = 0; i < NBUF; i++) begin
            free_cnt = free_cnt + CW'(!st_q.used[i]);
        end
    end

    always_comb begin
        st_d = st_q;
        if (clr_all) st_d.used = '0;
        else         st_d.used = (st_q.used & ~rel_mask) | rx_set | reg_set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R11: simultaneous claims never receive the same buffer
    p_distinct_claims_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_take && reg_take && rx_ok && reg_ok) |-> (rx_idx != reg_idx));

    // R2: a granted register allocation marks that buffer as used next cycle
    p_grant_marks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_take && reg_ok && !clr_all) |=> st_q.used[$past(reg_idx)]);
endmodule

// File: rtl/pba_unit.sv
module pba_unit
    import pba_pkg::*;
#(
    parameter int NBUF = 4,
    parameter int IDXW = $clog2(NBUF),
    parameter int CW   = $clog2(NBUF + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [3:0]           reg_addr,
    input  logic                 reg_we,
    input  logic [7:0]           reg_wdata,
    output logic [7:0]           reg_rdata,
    output logic                 irq,
    input  logic                 tx_start,
    input  logic                 tx_done,
    input  logic [IDXW-1:0]      tx_done_num,
    output logic                 tx_req,
    output logic [CW-1:0]        tx_pend_cnt,
    output logic [NBUF*IDXW-1:0] tx_pend_list,
    input  logic                 rx_req,
    output logic [IDXW-1:0]      rx_buf_num,
    output logic                 rx_pool_full
);
    typedef struct packed {
        logic [BANKW-1:0] bank;
        logic [IDXW-1:0]  pnum;
        logic [DW-1:0]    result;
        logic             auto_rel;
        logic [DW-1:0]    status;
        logic [DW-1:0]    mask;
    } unit_st_t;

    unit_st_t st_d, st_q;

    logic     wr_b0, wr_b2;
    pool_op_e op;
    logic cmd_alloc, cmd_rst_pool, cmd_pop_rx, cmd_pop_rx_rel;
    logic cmd_release, cmd_queue, cmd_rst_txq, ack_wr, ack_tx;
    logic rx_take, done_eff;
    logic [NBUF-1:0] rel_mask;

    logic [IDXW-1:0] rx_idx, reg_idx;
    logic            rx_ok, reg_ok, pool_full;
    logic [CW-1:0]   free_cnt;

    logic [CW-1:0]        pend_cnt, done_cnt, rxq_cnt;
    logic [IDXW-1:0]      pend_head, done_head, rxq_head;
    logic [NBUF*IDXW-1:0] pend_list, unused_done_list, unused_rx_list;
    logic [DW-1:0]        status_rd;

    // command decode
    always_comb begin
        wr_b0          = reg_we && st_q.bank == BANKW'(0);
        wr_b2          = reg_we && st_q.bank == BANKW'(2);
        op             = pool_op_e'(reg_wdata[7:5]);
        cmd_alloc      = wr_b2 && reg_addr == B2_CMD && op == OP_ALLOC;
        cmd_rst_pool   = wr_b2 && reg_addr == B2_CMD && op == OP_RST_POOL;
        cmd_pop_rx     = wr_b2 && reg_addr == B2_CMD && op == OP_POP_RX;
        cmd_pop_rx_rel = wr_b2 && reg_addr == B2_CMD && op == OP_POP_RX_REL;
        cmd_release    = wr_b2 && reg_addr == B2_CMD && op == OP_RELEASE;
        cmd_queue      = wr_b2 && reg_addr == B2_CMD && op == OP_QUEUE_TX;
        cmd_rst_txq    = wr_b2 && reg_addr == B2_CMD && op == OP_RST_TXQ;
        ack_wr         = wr_b2 && reg_addr == B2_STATUS;
        ack_tx         = ack_wr && reg_wdata[ST_TX];
        rx_take        = rx_req && !cmd_rst_pool;
        done_eff       = tx_done && !cmd_rst_pool && !cmd_rst_txq;
        rel_mask       = '0;
        if (cmd_release) rel_mask = rel_mask | (NBUF'(1) << st_q.pnum);
        if (cmd_pop_rx_rel && rxq_cnt != '0) rel_mask = rel_mask | (NBUF'(1) << rxq_head);
        if (done_eff && st_q.auto_rel) rel_mask = rel_mask | (NBUF'(1) << tx_done_num);
    end

    pba_pool #(.NBUF(NBUF), .IDXW(IDXW), .CW(CW)) u_pool (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_all  (cmd_rst_pool),
        .rx_take  (rx_take),
        .reg_take (cmd_alloc),
        .rel_mask (rel_mask),
        .rx_idx   (rx_idx),
        .rx_ok    (rx_ok),
        .reg_idx  (reg_idx),
        .reg_ok   (reg_ok),
        .free_cnt (free_cnt),
        .full     (pool_full)
    );

    pba_queue #(.DEPTH(NBUF), .IDXW(IDXW), .CW(CW)) u_pend_q (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cmd_rst_pool || cmd_rst_txq || tx_start),
        .pop      (1'b0),
        .push     (cmd_queue),
        .push_val (st_q.pnum),
        .cnt      (pend_cnt),
        .head     (pend_head),
        .entries  (pend_list)
    );

    pba_queue #(.DEPTH(NBUF), .IDXW(IDXW), .CW(CW)) u_done_q (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cmd_rst_pool || cmd_rst_txq),
        .pop      (ack_tx),
        .push     (done_eff && !st_q.auto_rel),
        .push_val (tx_done_num),
        .cnt      (done_cnt),
        .head     (done_head),
        .entries  (unused_done_list)
    );

    pba_queue #(.DEPTH(NBUF), .IDXW(IDXW), .CW(CW)) u_rx_q (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cmd_rst_pool),
        .pop      (cmd_pop_rx || cmd_pop_rx_rel),
        .push     (rx_take && rx_ok),
        .push_val (rx_idx),
        .cnt      (rxq_cnt),
        .head     (rxq_head),
        .entries  (unused_rx_list)
    );

    // status view: queue-derived bits override the stored copy
    always_comb begin
        status_rd         = st_q.status;
        status_rd[ST_RCV] = rxq_cnt != '0;
        status_rd[ST_TX]  = done_cnt != '0;
        status_rd[ST_TXE] = pend_cnt == '0;
    end

    // next-state logic for the register file
    always_comb begin
        st_d = st_q;
        if (reg_we && reg_addr == OFF_BANK) st_d.bank = reg_wdata[BANKW-1:0];
        if (wr_b0 && reg_addr == B0_CTRL)   st_d.auto_rel = reg_wdata[0];
        if (wr_b2 && reg_addr == B2_PNUM)   st_d.pnum = reg_wdata[IDXW-1:0];
        if (wr_b2 && reg_addr == B2_MASK)   st_d.mask = reg_wdata;
        if (ack_wr) st_d.status = st_q.status & ~(reg_wdata & ACK_MASK);
        if (cmd_alloc) begin
            st_d.result          = reg_ok ? DW'(reg_idx) : FAIL_CODE;
            st_d.status[ST_ALLOC] = reg_ok;
        end
        if (cmd_rst_pool) begin
            st_d.result           = '0;
            st_d.status[ST_ALLOC] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // register read mux
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == OFF_BANK) begin
            reg_rdata = DW'(st_q.bank);
        end else if (st_q.bank == BANKW'(0)) begin
            case (reg_addr)
                B0_SIZE: reg_rdata = DW'(NBUF);
                B0_FREE: reg_rdata = DW'(free_cnt);
                B0_CTRL: reg_rdata = DW'(st_q.auto_rel);
                default: reg_rdata = '0;
            endcase
        end else if (st_q.bank == BANKW'(2)) begin
            case (reg_addr)
                B2_PNUM:   reg_rdata = DW'(st_q.pnum);
                B2_RESULT: reg_rdata = st_q.result;
                B2_TXDONE: reg_rdata = (done_cnt == '0) ? FAIL_CODE : DW'(done_head);
                B2_RXHEAD: reg_rdata = (rxq_cnt == '0) ? FAIL_CODE : DW'(rxq_head);
                B2_STATUS: reg_rdata = status_rd;
                B2_MASK:   reg_rdata = st_q.mask;
                default:   reg_rdata = '0;
            endcase
        end
    end

    assign irq          = |(status_rd & st_q.mask);
    assign tx_req       = pend_cnt != '0;
    assign tx_pend_cnt  = pend_cnt;
    assign tx_pend_list = pend_list;
    assign rx_buf_num   = rx_idx;
    assign rx_pool_full = pool_full;

    logic unused_sig;
    assign unused_sig = ^{unused_done_list, unused_rx_list, pend_head};

    // R2: a refused allocation leaves the failure code in the result register
    p_fail_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_alloc && !reg_ok) |=> st_q.result == FAIL_CODE);

    // R4: a transmit start with no concurrent queue command empties the pending queue
    p_drain_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_start && !cmd_queue) |=> pend_cnt == '0);

    // R5: with auto-release on, a completion never lengthens the completed queue
    p_auto_bypass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_eff && st_q.auto_rel && !ack_tx) |=> $stable(done_cnt));

    // R9: the pool reset leaves nothing allocated or queued
    p_pool_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rst_pool |=> (free_cnt == CW'(NBUF) && rxq_cnt == '0 && done_cnt == '0 && pend_cnt == '0));

    // R8: a receive claim with the pool full leaves the receive queue unchanged
    p_rx_full_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_req && pool_full && !cmd_pop_rx && !cmd_pop_rx_rel && !cmd_rst_pool) |=> $stable(rxq_cnt));
endmodule

// File: tb/pba_unit_tb.sv
module pba_unit_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] reg_addr = '0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq;
    logic       tx_start = 1'b0;
    logic       tx_done = 1'b0;
    logic [1:0] tx_done_num = '0;
    logic       tx_req;
    logic [2:0] tx_pend_cnt;
    logic [7:0] tx_pend_list;
    logic       rx_req = 1'b0;
    logic [1:0] rx_buf_num;
    logic       rx_pool_full;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    pba_unit u_dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .tx_start(tx_start), .tx_done(tx_done), .tx_done_num(tx_done_num),
        .tx_req(tx_req), .tx_pend_cnt(tx_pend_cnt), .tx_pend_list(tx_pend_list),
        .rx_req(rx_req), .rx_buf_num(rx_buf_num), .rx_pool_full(rx_pool_full)
    );

    localparam logic [7:0] C_ALLOC = 8'h20, C_RSTP = 8'h40, C_POPRX = 8'h60,
                           C_POPREL = 8'h80, C_REL = 8'hA0, C_QTX = 8'hC0, C_RSTTX = 8'hE0;

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse_done(input logic [1:0] n);
        @(negedge clk);
        tx_done = 1'b1; tx_done_num = n;
        @(negedge clk);
        tx_done = 1'b0;
    endtask

    task automatic pulse_rx();
        @(negedge clk);
        rx_req = 1'b1;
        @(negedge clk);
        rx_req = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        tx_start = 1'b1;
        @(negedge clk);
        tx_start = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        wr(4'd14, 8'd0);
        rd(4'd0, d);  chk("R1 size", d, 4);
        rd(4'd1, d);  chk("R1 free", d, 4);
        wr(4'd14, 8'd2);
        rd(4'd4, d);  chk("R1 done head", d, 8'h80);
        rd(4'd5, d);  chk("R1 rx head", d, 8'h80);
        rd(4'd12, d); chk("R1 status", d, 8'h04);
        rd(4'd13, d); chk("R1 mask", d, 0);
        chk("R1 irq", irq, 0);
    endtask

    task automatic t_alloc();
        logic [7:0] d;
        wr(4'd0, C_RSTP);
        for (int i = 0; i < 4; i++) begin
            wr(4'd0, C_ALLOC);
            rd(4'd3, d); chk("R2 alloc index", d, i);
        end
        rd(4'd12, d); chk("R2 alloc bit set", d & 8'h08, 8'h08);
        wr(4'd0, C_ALLOC);
        rd(4'd3, d);  chk("R2 fail code", d, 8'h80);
        rd(4'd12, d); chk("R2 alloc bit clear", d & 8'h08, 0);
        wr(4'd2, 8'd2);
        wr(4'd0, C_REL);
        wr(4'd14, 8'd0);
        rd(4'd1, d);  chk("R3 free after release", d, 1);
        wr(4'd14, 8'd2);
        wr(4'd0, C_ALLOC);
        rd(4'd3, d);  chk("R3 reuse released", d, 2);
    endtask

    task automatic t_tx();
        logic [7:0] d;
        wr(4'd0, C_RSTP);
        wr(4'd0, C_ALLOC);
        wr(4'd0, C_ALLOC);
        wr(4'd2, 8'd1); wr(4'd0, C_QTX);
        wr(4'd2, 8'd0); wr(4'd0, C_QTX);
        chk("R4 tx_req", tx_req, 1);
        chk("R4 pend cnt", tx_pend_cnt, 2);
        chk("R4 pend head", tx_pend_list[1:0], 1);
        chk("R4 pend second", tx_pend_list[3:2], 0);
        rd(4'd12, d); chk("R4 txempty low", d & 8'h04, 0);
        pulse_start();
        chk("R4 drained", tx_pend_cnt, 0);
        chk("R4 tx_req low", tx_req, 0);
        rd(4'd12, d); chk("R4 txempty back", d & 8'h04, 8'h04);
    endtask

    task automatic t_done();
        logic [7:0] d;
        pulse_done(2'd1);
        pulse_done(2'd0);
        rd(4'd4, d);  chk("R5 done head", d, 1);
        rd(4'd12, d); chk("R5 tx bit", d & 8'h02, 8'h02);
        wr(4'd12, 8'h02);
        rd(4'd4, d);  chk("R6 pop head", d, 0);
        rd(4'd12, d); chk("R6 tx bit held", d & 8'h02, 8'h02);
        wr(4'd12, 8'h02);
        rd(4'd4, d);  chk("R6 empty head", d, 8'h80);
        rd(4'd12, d); chk("R6 tx bit clear", d & 8'h02, 0);
        pulse_done(2'd0); pulse_done(2'd1); pulse_done(2'd2);
        pulse_done(2'd3); pulse_done(2'd2);
        for (int i = 0; i < 4; i++) begin
            rd(4'd4, d); chk("R5 full queue order", d, i);
            wr(4'd12, 8'h02);
        end
        rd(4'd4, d);  chk("R5 fifth dropped", d, 8'h80);
        wr(4'd12, 8'hFF);
        rd(4'd12, d); chk("R6 alloc unackable", d, 8'h0C);
        wr(4'd14, 8'd0); wr(4'd2, 8'd1);
        rd(4'd1, d);  chk("R5 free before auto", d, 2);
        pulse_done(2'd1);
        rd(4'd1, d);  chk("R5 auto release", d, 3);
        wr(4'd2, 8'd0); wr(4'd14, 8'd2);
        rd(4'd4, d);  chk("R5 auto bypass", d, 8'h80);
    endtask

    task automatic t_irq();
        wr(4'd13, 8'h04);
        chk("R7 irq on", irq, 1);
        wr(4'd13, 8'h01);
        chk("R7 irq off", irq, 0);
        wr(4'd13, 8'h00);
    endtask

    task automatic t_rx();
        logic [7:0] d;
        wr(4'd0, C_RSTP);
        chk("R8 next buf", rx_buf_num, 0);
        pulse_rx();
        rd(4'd5, d);  chk("R8 rx head", d, 0);
        rd(4'd12, d); chk("R8 rcv bit", d & 8'h01, 1);
        chk("R8 next buf after", rx_buf_num, 1);
        pulse_rx();
        wr(4'd0, C_POPRX);
        rd(4'd5, d);  chk("R8 pop head", d, 1);
        wr(4'd0, C_POPREL);
        rd(4'd5, d);  chk("R8 pop rel empty", d, 8'h80);
        rd(4'd12, d); chk("R8 rcv clear", d & 8'h01, 0);
        wr(4'd14, 8'd0);
        rd(4'd1, d);  chk("R8 free after pop rel", d, 3);
        wr(4'd14, 8'd2);
        for (int i = 0; i < 4; i++) pulse_rx();
        chk("R8 pool full", rx_pool_full, 1);
        for (int i = 1; i < 4; i++) begin
            rd(4'd5, d); chk("R8 rx order", d, i);
            wr(4'd0, C_POPRX);
        end
        rd(4'd5, d);  chk("R8 full claim ignored", d, 8'h80);
    endtask

    task automatic t_resets();
        logic [7:0] d;
        wr(4'd0, C_RSTP);
        wr(4'd0, C_ALLOC); wr(4'd0, C_ALLOC);
        wr(4'd2, 8'd0); wr(4'd0, C_QTX);
        pulse_done(2'd1);
        wr(4'd0, C_RSTTX);
        chk("R9 txq pend cleared", tx_pend_cnt, 0);
        rd(4'd4, d);  chk("R9 txq done cleared", d, 8'h80);
        wr(4'd14, 8'd0);
        rd(4'd1, d);  chk("R9 txq keeps pool", d, 2);
        wr(4'd14, 8'd2);
        pulse_rx();
        wr(4'd0, C_RSTP);
        rd(4'd3, d);  chk("R9 result cleared", d, 0);
        rd(4'd5, d);  chk("R9 rx cleared", d, 8'h80);
        rd(4'd12, d); chk("R9 status", d, 8'h04);
        wr(4'd14, 8'd0);
        rd(4'd1, d);  chk("R9 pool cleared", d, 4);
    endtask

    task automatic t_bank();
        logic [7:0] d;
        wr(4'd14, 8'd5);
        rd(4'd14, d); chk("R10 bank read", d, 5);
        rd(4'd0, d);  chk("R10 unmapped bank", d, 0);
        wr(4'd13, 8'hFF);
        wr(4'd14, 8'd2);
        rd(4'd13, d); chk("R10 write ignored", d, 0);
        rd(4'd7, d);  chk("R10 unmapped offset", d, 0);
    endtask

    task automatic t_race();
        logic [7:0] d;
        wr(4'd0, C_RSTP);
        @(negedge clk);
        reg_addr = 4'd0; reg_wdata = C_ALLOC; reg_we = 1'b1; rx_req = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; rx_req = 1'b0;
        rd(4'd5, d); chk("R11 rx gets lowest", d, 0);
        rd(4'd3, d); chk("R11 alloc gets next", d, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_alloc();
        t_tx();
        t_done();
        t_irq();
        t_rx();
        t_resets();
        t_bank();
        t_race();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule